// File: doc/BRIEF.md
# Phase Lock Detector with Hysteresis

This block decides whether a phase-tracking loop can be trusted. It receives one signed phase-error sample per tick of the loop's sample clock, which arrives here as a one-cycle valid strobe. The absolute value of each sample is compared against a programmable threshold. A sample whose magnitude is strictly below the threshold counts as "inside the window".

Lock is declared after a power-of-two run of consecutive inside-window samples. The run length is set by a 5-bit lock exponent. Once lock is declared, the flag holds. It drops only when a separate, shorter-or-longer power-of-two run of consecutive outside-window samples is seen. That run length is set by a 3-bit unlock exponent. Because the two windows are set independently, the detector can be made quick to lose lock and slow to gain it, or the reverse. After an unlock the lock run starts again from zero.

The flag is meant to be combined by the system with reference-valid or holdover status. During holdover the detector can keep reporting lock even though no reference is present.

Top module: `pd_phase_lock_det`

## Requirements
- R1: A sample is inside the window when |phase_err| < thresh (unsigned compare, strictly less). phase_err is two's complement. The most negative code has magnitude 2^(ERR_W-1), and a sample whose magnitude equals thresh is outside.
- R2: From the unlocked state, `locked` goes high on the clock edge that registers the 2^X-th consecutive valid inside-window sample, where X = lock_exp. It is still low after the edge of the sample before that one.
- R3: A lock_exp value above LOCK_EXP_MAX (default 20) behaves as LOCK_EXP_MAX.
- R4: While unlocked, a valid outside-window sample restarts the lock run from zero.
- R5: Cycles with smp_vld low neither advance nor break either run, whatever phase_err holds.
- R6: While locked, the flag stays high through valid inside-window samples and through outside-window runs shorter than the unlock length. A valid inside-window sample restarts the unlock run.
- R7: While locked, `locked` falls on the edge that registers the 2^(Y+1)-th consecutive valid outside-window sample, where Y = unlock_exp.
- R8: After an unlock, a full new run of 2^X inside-window samples is needed to lock again. Outside-window samples seen while unlocked do not count toward any later unlock.
- R9: A synchronous active-high rst clears `locked` and both runs on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | One-cycle strobe marking a new phase-error sample |
| phase_err | input | ERR_W | Signed phase-error sample |
| thresh | input | ERR_W | Unsigned magnitude threshold |
| lock_exp | input | 5 | Lock run exponent X, run length 2^X |
| unlock_exp | input | 3 | Unlock run exponent Y, run length 2^(Y+1) |
| locked | output | 1 | Sticky lock indication |

## Verification
A wrong run count shows up at `locked` as an edge one or more sample ticks early or late. The bench therefore compares the flag after every clock against a model, so any offset shows on the very cycle the edge should have happened. A run that is not cleared when it should be shows up as a premature lock or unlock on a later run. The directed sequences place a broken run, an ignored strobe gap, or a re-lock right before the deciding sample so that such a leak changes the flag at once. Errors at the magnitude boundary (equal value, most negative code) show up as a flag that locks when it should not, within one lock run.

// File: rtl/pd_lock_pkg.sv
package pd_lock_pkg;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_HELD = 1'b1
    } lock_st_e;

    typedef struct packed {
        lock_st_e st;
    } det_state_t;

endpackage

// File: rtl/pd_err_mag.sv
module pd_err_mag #(
    parameter int ERR_W = 12
) (
    input  logic signed [ERR_W-1:0] phase_err,
    input  logic        [ERR_W-1:0] thresh,
    output logic                    in_win
);
    logic [ERR_W-1:0] mag;

    always_comb begin
        if (phase_err[ERR_W-1]) begin
            mag = ERR_W'(-phase_err);
        end else begin
            mag = phase_err;
        end
        in_win = (mag < thresh);
    end

endmodule

// File: rtl/pd_span_decode.sv
module pd_span_decode #(
    parameter int EXP_W   = 5,
    parameter int OFFSET  = 0,
    parameter int EXP_MAX = 20,
    parameter int CW      = 21
) (
    input  logic [EXP_W-1:0] exp_in,
    output logic [CW-1:0]    span
);
    localparam int EW = EXP_W + 2;

    logic [EW-1:0] eff;

    always_comb begin
        eff = EW'(exp_in) + EW'(OFFSET);
        if (eff > EW'(EXP_MAX)) begin
            eff = EW'(EXP_MAX);
        end
        span = CW'(1) << eff;
    end

endmodule

// File: rtl/pd_run_counter.sv
module pd_run_counter #(
    parameter int CW = 21
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          bump,
    input  logic [CW-1:0] span,
    output logic          hit,
    output logic [CW-1:0] count
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } run_state_t;

    run_state_t s_d, s_q;
    logic [CW:0] next_len;

    always_comb begin
        s_d      = s_q;
        next_len = {1'b0, s_q.cnt} + (CW+1)'(1);
        hit      = 1'b0;
        if (clear) begin
            s_d.cnt = '0;
        end else if (bump) begin
            if (next_len >= {1'b0, span}) begin
                hit     = 1'b1;
                s_d.cnt = '0;
            end else begin
                s_d.cnt = next_len[CW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign count = s_q.cnt;

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
        clear |=> (count == '0)); // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!clear && !bump) |=> $stable(count)); // R5

endmodule

// File: rtl/pd_phase_lock_det.sv
module pd_phase_lock_det #(
    parameter int ERR_W        = 12,
    parameter int LOCK_EXP_MAX = 20
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_vld,
    input  logic signed [ERR_W-1:0] phase_err,
    input  logic        [ERR_W-1:0] thresh,
    input  logic        [4:0]       lock_exp,
    input  logic        [2:0]       unlock_exp,
    output logic                    locked
);
    import pd_lock_pkg::*;

    localparam int LCW          = LOCK_EXP_MAX + 1;
    localparam int UNL_EXP_MAX  = 8;
    localparam int UCW          = UNL_EXP_MAX + 1;

    det_state_t st_d, st_q;

    logic           in_win;
    logic [LCW-1:0] lock_span;
    logic [UCW-1:0] unl_span;
    logic           lock_clr, lock_bump, lock_hit;
    logic           unl_clr, unl_bump, unl_hit;
    logic [LCW-1:0] lock_cnt;
    logic [UCW-1:0] unl_cnt;

    pd_err_mag #(.ERR_W(ERR_W)) u_mag (
        .phase_err (phase_err),
        .thresh    (thresh),
        .in_win    (in_win)
    );

    pd_span_decode #(.EXP_W(5), .OFFSET(0), .EXP_MAX(LOCK_EXP_MAX), .CW(LCW)) u_lock_span (
        .exp_in (lock_exp),
        .span   (lock_span)
    );

    pd_span_decode #(.EXP_W(3), .OFFSET(1), .EXP_MAX(UNL_EXP_MAX), .CW(UCW)) u_unl_span (
        .exp_in (unlock_exp),
        .span   (unl_span)
    );

    always_comb begin
        lock_clr  = (st_q.st == ST_HELD) || (smp_vld && !in_win);
        lock_bump = (st_q.st == ST_HUNT) && smp_vld && in_win;
        unl_clr   = (st_q.st == ST_HUNT) || (smp_vld && in_win);
        unl_bump  = (st_q.st == ST_HELD) && smp_vld && !in_win;
    end

    pd_run_counter #(.CW(LCW)) u_lock_run (
        .clk   (clk),
        .rst   (rst),
        .clear (lock_clr),
        .bump  (lock_bump),
        .span  (lock_span),
        .hit   (lock_hit),
        .count (lock_cnt)
    );

    pd_run_counter #(.CW(UCW)) u_unl_run (
        .clk   (clk),
        .rst   (rst),
        .clear (unl_clr),
        .bump  (unl_bump),
        .span  (unl_span),
        .hit   (unl_hit),
        .count (unl_cnt)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.st)
            ST_HUNT: if (lock_hit) st_d.st = ST_HELD;
            ST_HELD: if (unl_hit)  st_d.st = ST_HUNT;
            default: st_d.st = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{st: ST_HUNT};
        end else begin
            st_q <= st_d;
        end
    end

    assign locked = (st_q.st == ST_HELD);

    AST_RISE_ON_IN_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(smp_vld && in_win)); // R2
    AST_FALL_ON_OUT_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        ($fell(locked) && !$past(rst)) |-> $past(smp_vld && !in_win)); // R7
    AST_STICKY_FLAG: assert property (@(posedge clk) disable iff (rst)
        (locked && !(smp_vld && !in_win)) |=> locked); // R6
    AST_LOCK_RUN_IDLE_WHEN_HELD: assert property (@(posedge clk) disable iff (rst)
        locked |-> (lock_cnt == '0)); // R8
    AST_UNL_RUN_IDLE_WHEN_HUNT: assert property (@(posedge clk) disable iff (rst)
        !locked |-> (unl_cnt == '0)); // R8
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> !locked); // R9

endmodule

// File: tb/test_pd_phase_lock_det.sv
module test_pd_phase_lock_det;

    localparam int ERR_W   = 12;
    localparam int EXP_MAX = 6;

    logic                    clk = 1'b0;
    logic                    rst;
    logic                    smp_vld;
    logic signed [ERR_W-1:0] phase_err;
    logic        [ERR_W-1:0] thresh;
    logic        [4:0]       lock_exp;
    logic        [2:0]       unlock_exp;
    logic                    locked;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    bit m_locked = 0;
    int m_lrun   = 0;
    int m_urun   = 0;

    always #4 clk = ~clk;

    pd_phase_lock_det #(.ERR_W(ERR_W), .LOCK_EXP_MAX(EXP_MAX)) i_pd_phase_lock_det (
        .clk        (clk),
        .rst        (rst),
        .smp_vld    (smp_vld),
        .phase_err  (phase_err),
        .thresh     (thresh),
        .lock_exp   (lock_exp),
        .unlock_exp (unlock_exp),
        .locked     (locked)
    );

    function automatic bit inside_win(int e, int thr);
        int mag;
        mag = (e < 0) ? -e : e;
        return mag < thr;
    endfunction

    function automatic int lock_len(int x);
        return 1 << ((x > EXP_MAX) ? EXP_MAX : x);
    endfunction

    function automatic int unl_len(int y);
        return 1 << (y + 1);
    endfunction

    task automatic check(bit got, bit exp, string tag);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: locked=%0b expected=%0b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic step(bit r, bit v, int e, string tag);
        bit inw;
        rst       = r;
        smp_vld   = v;
        phase_err = e[ERR_W-1:0];
        @(posedge clk);
        inw = inside_win(e, int'(thresh));
        if (r) begin
            m_locked = 0; m_lrun = 0; m_urun = 0;
        end else if (v) begin
            if (!m_locked) begin
                if (inw) begin
                    m_lrun++;
                    if (m_lrun >= lock_len(int'(lock_exp))) begin
                        m_locked = 1; m_lrun = 0;
                    end
                end else begin
                    m_lrun = 0;
                end
            end else begin
                if (!inw) begin
                    m_urun++;
                    if (m_urun >= unl_len(int'(unlock_exp))) begin
                        m_locked = 0; m_urun = 0;
                    end
                end else begin
                    m_urun = 0;
                end
            end
        end
        @(negedge clk);
        check(locked, m_locked, tag);
    endtask

    task automatic run_in(int n, string tag);
        for (int i = 0; i < n; i++) step(0, 1, 5, tag);
    endtask

    task automatic run_out(int n, string tag);
        for (int i = 0; i < n; i++) step(0, 1, -900, tag);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: run did not complete");
        finish_up();
    end

    initial begin
        rst = 1; smp_vld = 0; phase_err = '0; thresh = 12'd100;
        lock_exp = 5'd0; unlock_exp = 3'd0;
        @(negedge clk);
        step(1, 0, 0, "R9 reset");
        check(locked, 1'b0, "R9 reset state");

        // R2 X=0: single inside sample locks
        step(0, 1, 5, "R2 x0");
        check(locked, 1'b1, "R2 lock after 1 sample");
        // R6 short outside run, then inside resets unlock run
        run_out(1, "R6 short out");
        step(0, 1, -20, "R6 in resets");
        run_out(1, "R6 after reset");
        check(locked, 1'b1, "R6 still locked");
        // R7 Y=0: two outside samples unlock
        run_out(1, "R7 second out");
        check(locked, 1'b0, "R7 unlock after 2");

        // R2/R4/R5 with X=3
        lock_exp = 5'd3; unlock_exp = 3'd1;
        run_in(7, "R2 seven in");
        check(locked, 1'b0, "R2 not locked at 7");
        step(0, 0, 2000, "R5 gap");
        step(0, 0, -2000, "R5 gap");
        check(locked, 1'b0, "R5 gap no effect");
        step(0, 1, 700, "R4 break");
        run_in(7, "R4 rebuild");
        check(locked, 1'b0, "R4 restart from zero");
        step(0, 1, 0, "R2 eighth");
        check(locked, 1'b1, "R2 lock at 8");
        // R7 Y=1: four outs with gaps between
        run_out(3, "R7 three out");
        step(0, 0, 3, "R5 gap locked");
        check(locked, 1'b1, "R7 still locked at 3");
        run_out(1, "R7 fourth out");
        check(locked, 1'b0, "R7 unlock at 4");
        // R8 relock needs full run; prior outs do not count
        run_out(3, "R8 out while unlocked");
        run_in(7, "R8 rebuild");
        check(locked, 1'b0, "R8 not locked at 7");
        step(0, 1, 1, "R8 eighth");
        check(locked, 1'b1, "R8 relocked");
        run_out(3, "R8 outs");
        check(locked, 1'b1, "R8 unlock run fresh");
        run_out(1, "R8 unlock");

        // R1 boundaries
        lock_exp = 5'd0;
        step(0, 1, 100, "R1 equal");
        check(locked, 1'b0, "R1 equal is outside");
        step(0, 1, -100, "R1 neg equal");
        check(locked, 1'b0, "R1 neg equal outside");
        thresh = 12'd2048;
        step(0, 1, -2048, "R1 most negative");
        check(locked, 1'b0, "R1 most negative equal");
        thresh = 12'd2049;
        step(0, 1, -2048, "R1 most negative in");
        check(locked, 1'b1, "R1 most negative below");
        step(1, 0, 0, "R9 reset locked");
        check(locked, 1'b0, "R9 reset clears");
        thresh = 12'd100;

        // R3 clamp: X=9 acts as 6
        lock_exp = 5'd9;
        run_in(63, "R3 63 in");
        check(locked, 1'b0, "R3 not at 63");
        step(0, 1, 0, "R3 64th");
        check(locked, 1'b1, "R3 clamped lock at 64");
        step(1, 0, 0, "R9 reset");

        // random phase
        for (int seg = 0; seg < 40; seg++) begin
            int thr;
            thr = 1 + int'($urandom_range(400));
            thresh     = thr[ERR_W-1:0];
            lock_exp   = 5'($urandom_range(7));
            unlock_exp = 3'($urandom_range(2));
            for (int k = 0; k < 300; k++) begin
                bit r, v;
                int e;
                r = ($urandom_range(199) == 0);
                v = ($urandom_range(3) != 0);
                if ($urandom_range(3) != 0)
                    e = int'($urandom_range(2 * thr)) - thr;
                else
                    e = int'($urandom_range(4095)) - 2048;
                step(r, v, e, "R2 R4 R6 R7 random");
            end
        end
        finish_up();
    end

    initial void'($urandom(32'd1234));

endmodule